// File: doc/BRIEF.md
# UART Receive FIFO Interrupt Controller

This block produces the receive-side interrupts of a UART running in FIFO mode. It does not hold the received characters. It watches the occupancy count of an external receive FIFO, a strobe that marks each character written into that FIFO, a strobe for each host read, and a line-status error flag. From these it derives a threshold interrupt, a character time-out interrupt, the data-ready status bit and a 4-bit identification code for the receive sources.

The time-out works from a baud-rate clock enable. It counts sixteen enable ticks per serial bit, so the delay scales with the line speed. The frame length comes from the programmed data width, parity and stop-bit settings. A time-out is raised when the FIFO holds data but has seen no new character and no host read for four character times.

The block is meant to sit between the receive FIFO and the register decode of a larger UART. All outputs are combinational over a small amount of internal state, so a register read sees the current condition.

Top module: `rx_irq_ctl`

## Requirements
- R1: With any of `fifoEn`, `rxDataIe`, `rxLineIe` low, `dataAvailIrq` and `timeoutIrq` are 0 and `irqId` is 0x1 (nothing pending).
- R2: While enabled, `dataAvailIrq` is 1 in exactly those cycles where `fifoCount >= trigLevel`, with no added latency (`trigLevel` is at least 1).
- R3: While enabled, `irqId` follows a fixed priority. It is 0x6 when `lineErr` is high. Otherwise it is 0x4 when the data-available condition holds, then 0xC when a time-out is pending. With no source active it is 0x1.
- R4: `dataReady` is 1 after any clock edge where `charIn` was high. It is 0 after an edge where `fifoCount` was 0 and `charIn` was low, and holds otherwise. The interrupt enables do not affect it.
- R5: One character time is 16 × (7 + `dataBits` + `parityEn` + `twoStop`) baud ticks, where `dataBits` 0..3 selects 5..8 data bits. The idle timer advances only on edges with `baudTick` high. A time-out becomes pending at the first edge where the timer has reached four character times and neither `charIn` nor `hostRead` is high.
- R6: While no time-out is pending, a `charIn` or `hostRead` restarts the idle timer from zero. The timer is held at zero while `fifoCount` is 0 or `fifoEn` is low.
- R7: While a time-out is pending, `charIn` neither clears it nor restarts the timer. A `hostRead` clears both the pending time-out and the timer at that edge.
- R8: A pending time-out is dropped at any edge where `fifoCount` is 0 or `fifoEn` is low.
- R9: `timeoutIrq` is high when a time-out is pending and the enables of R1 are all set. Clearing an interrupt enable masks the output but leaves the pending state in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fifoEn | input | 1 | FIFO mode enable |
| rxDataIe | input | 1 | Receive-data interrupt enable |
| rxLineIe | input | 1 | Line-status interrupt enable |
| fifoCount | input | CNT_W | Characters currently held in the receive FIFO |
| trigLevel | input | CNT_W | Programmed trigger threshold |
| charIn | input | 1 | One-cycle strobe: character written into the FIFO |
| hostRead | input | 1 | One-cycle strobe: host read one character |
| lineErr | input | 1 | Line-status error pending |
| dataBits | input | 2 | Data width code, 0..3 for 5..8 bits |
| parityEn | input | 1 | Parity bit present in frame |
| twoStop | input | 1 | Two stop bits in frame |
| baudTick | input | 1 | Baud-rate clock enable, 16 per bit |
| dataAvailIrq | output | 1 | Threshold interrupt |
| timeoutIrq | output | 1 | Character time-out interrupt |
| dataReady | output | 1 | Data-ready status bit |
| irqId | output | 4 | Receive interrupt identification code |

## Verification
The bench aims at the exact edge where the idle timer reaches four character times, for both the shortest and the longest frame. A design that is off by one tick, or that ignores parity or the second stop bit, raises the time-out one cycle early or late. It also checks that a character arriving while a time-out is pending leaves the time-out in place, and that a single read clears it. A design that treated both strobes alike would drop the interrupt without any read. Further cases cover priority at the trigger boundary with a line error present, a FIFO that empties while a time-out is pending, and masking followed by unmasking. Wrong handling of these shows up as a wrong identification code or as a stale or lost time-out.

// File: rtl/rx_irq_pkg.sv
package rx_irq_pkg;

  // strobes from control to the timer datapath
  typedef struct packed {
    logic timerClr;
    logic timerRun;
  } tmrCtl_t;

  // conditions reported back by the datapath
  typedef struct packed {
    logic timerHit;
    logic fifoEmpty;
    logic atTrig;
  } dpStat_t;

  typedef enum logic [3:0] {
    ID_NONE = 4'h1,
    ID_DATA = 4'h4,
    ID_LINE = 4'h6,
    ID_TMO  = 4'hC
  } irqId_e;

endpackage

// File: rtl/rx_irq_dp.sv
module rx_irq_dp
  import rx_irq_pkg::*;
#(
  parameter int CNT_W         = 5,
  parameter int TICKS_PER_BIT = 16,
  parameter int TMO_CHARS     = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrCtl_t          ctl,
  input  logic [1:0]       dataBits,
  input  logic             parityEn,
  input  logic             twoStop,
  input  logic [CNT_W-1:0] fifoCount,
  input  logic [CNT_W-1:0] trigLevel,
  output dpStat_t          stat
);

  localparam int MAX_FRAME = 12;
  localparam int TMR_W     = $clog2(TMO_CHARS * TICKS_PER_BIT * MAX_FRAME + 1);
  localparam int PER_FRAME = TMO_CHARS * TICKS_PER_BIT;
  localparam bit POW2      = (PER_FRAME & (PER_FRAME - 1)) == 0;
  localparam int SHIFT     = $clog2(PER_FRAME);

  logic [3:0]       frameBits;
  logic [TMR_W-1:0] threshold;
  logic [TMR_W-1:0] tmr;

  // start + 5 data + 1 stop = 7, plus the programmable extras
  always_comb begin
    frameBits = 4'd7 + {2'b00, dataBits} + {3'b000, parityEn} + {3'b000, twoStop};
  end

  generate
    if (POW2) begin : g_shift
      always_comb threshold = TMR_W'(frameBits) << SHIFT;
    end else begin : g_mult
      always_comb threshold = TMR_W'(frameBits) * TMR_W'(PER_FRAME);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tmr <= '0;
    end else if (ctl.timerClr) begin
      tmr <= '0;
    end else if (ctl.timerRun && (tmr < threshold)) begin
      tmr <= tmr + TMR_W'(1);
    end
  end

  always_comb begin
    stat.timerHit  = (tmr >= threshold);
    stat.fifoEmpty = (fifoCount == '0);
    stat.atTrig    = (fifoCount >= trigLevel);
  end

  // R6: a clear strobe leaves the timer at zero
  a_r6_timer_clear: assert property (@(posedge clk) disable iff (!rstN)
    ctl.timerClr |=> (tmr == '0));

  // R5: one tick advances the timer by exactly one below the limit
  a_r5_timer_step: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.timerClr && ctl.timerRun && (tmr < threshold))
      |=> (tmr == $past(tmr) + TMR_W'(1)));

  // R5: without a tick the timer never advances
  a_r5_no_tick_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.timerClr && !ctl.timerRun) |=> $stable(tmr));

endmodule

// File: rtl/rx_irq_ctrl.sv
module rx_irq_ctrl
  import rx_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     fifoEn,
  input  logic     rxDataIe,
  input  logic     rxLineIe,
  input  logic     charIn,
  input  logic     hostRead,
  input  logic     lineErr,
  input  logic     baudTick,
  input  dpStat_t  stat,
  output tmrCtl_t  ctl,
  output logic     dataAvailIrq,
  output logic     timeoutIrq,
  output logic     dataReady,
  output logic [3:0] irqId
);

  logic active;
  logic toPend;
  logic timerHold;
  logic activity;
  irqId_e idSel;

  always_comb begin
    active    = fifoEn & rxDataIe & rxLineIe;
    timerHold = ~fifoEn | stat.fifoEmpty;
    activity  = charIn | hostRead;
  end

  // timer strobes: while pending only a read restarts it
  always_comb begin
    ctl.timerClr = timerHold | hostRead | (charIn & ~toPend);
    ctl.timerRun = baudTick & ~toPend;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      toPend <= 1'b0;
    end else if (timerHold) begin
      toPend <= 1'b0;
    end else if (toPend) begin
      if (hostRead) toPend <= 1'b0;
    end else if (stat.timerHit && !activity) begin
      toPend <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataReady <= 1'b0;
    end else if (charIn) begin
      dataReady <= 1'b1;
    end else if (stat.fifoEmpty) begin
      dataReady <= 1'b0;
    end
  end

  always_comb begin
    dataAvailIrq = active & stat.atTrig;
    timeoutIrq   = active & toPend;
    if (!active)           idSel = ID_NONE;
    else if (lineErr)      idSel = ID_LINE;
    else if (stat.atTrig)  idSel = ID_DATA;
    else if (toPend)       idSel = ID_TMO;
    else                   idSel = ID_NONE;
    irqId = idSel;
  end

  // R4: a stored character always shows as ready
  a_r4_ready_set: assert property (@(posedge clk) disable iff (!rstN)
    charIn |=> dataReady);

  // R4: an empty FIFO without a new character drops ready
  a_r4_ready_clear: assert property (@(posedge clk) disable iff (!rstN)
    (stat.fifoEmpty && !charIn) |=> !dataReady);

  // R7: one read clears a pending time-out
  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (toPend && hostRead) |=> !toPend);

  // R7: a new character does not disturb a pending time-out
  a_r7_char_keeps: assert property (@(posedge clk) disable iff (!rstN)
    (toPend && !hostRead && !timerHold) |=> toPend);

  // R8: empty FIFO or FIFO mode off drops the pending time-out
  a_r8_hold_drops: assert property (@(posedge clk) disable iff (!rstN)
    timerHold |=> !toPend);

  // R5: a time-out only starts after the timer reached its limit
  a_r5_rise_on_hit: assert property (@(posedge clk) disable iff (!rstN)
    $rose(toPend) |-> $past(stat.timerHit));

endmodule

// File: rtl/rx_irq_ctl.sv
module rx_irq_ctl
  import rx_irq_pkg::*;
#(
  parameter int CNT_W         = 5,
  parameter int TICKS_PER_BIT = 16,
  parameter int TMO_CHARS     = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fifoEn,
  input  logic             rxDataIe,
  input  logic             rxLineIe,
  input  logic [CNT_W-1:0] fifoCount,
  input  logic [CNT_W-1:0] trigLevel,
  input  logic             charIn,
  input  logic             hostRead,
  input  logic             lineErr,
  input  logic [1:0]       dataBits,
  input  logic             parityEn,
  input  logic             twoStop,
  input  logic             baudTick,
  output logic             dataAvailIrq,
  output logic             timeoutIrq,
  output logic             dataReady,
  output logic [3:0]       irqId
);

  tmrCtl_t tCtl;
  dpStat_t dStat;

  rx_irq_dp #(
    .CNT_W        (CNT_W),
    .TICKS_PER_BIT(TICKS_PER_BIT),
    .TMO_CHARS    (TMO_CHARS)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (tCtl),
    .dataBits (dataBits),
    .parityEn (parityEn),
    .twoStop  (twoStop),
    .fifoCount(fifoCount),
    .trigLevel(trigLevel),
    .stat     (dStat)
  );

  rx_irq_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .fifoEn      (fifoEn),
    .rxDataIe    (rxDataIe),
    .rxLineIe    (rxLineIe),
    .charIn      (charIn),
    .hostRead    (hostRead),
    .lineErr     (lineErr),
    .baudTick    (baudTick),
    .stat        (dStat),
    .ctl         (tCtl),
    .dataAvailIrq(dataAvailIrq),
    .timeoutIrq  (timeoutIrq),
    .dataReady   (dataReady),
    .irqId       (irqId)
  );

  // R1: disabled block raises nothing
  a_r1_quiet_when_off: assert property (@(posedge clk) disable iff (!rstN)
    !(fifoEn && rxDataIe && rxLineIe) |-> (!dataAvailIrq && !timeoutIrq && irqId == 4'h1));

endmodule

// File: tb/sim_rx_irq_ctl.sv
module sim_rx_irq_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fifoEn = 0, rxDataIe = 0, rxLineIe = 0;
  logic [CNT_W-1:0] fifoCount = '0, trigLevel = 5'd1;
  logic charIn = 0, hostRead = 0, lineErr = 0;
  logic [1:0] dataBits = 2'd0;
  logic parityEn = 0, twoStop = 0, baudTick = 0;
  logic dataAvailIrq, timeoutIrq, dataReady;
  logic [3:0] irqId;

  int testCnt = 0;
  int failCnt = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_irq_ctl #(.CNT_W(CNT_W)) u0 (.*);

  // reference model state
  int  mTimer = 0;
  bit  mPend = 0;
  bit  mReady = 0;

  always @(posedge clk) begin
    int thr;
    thr = 64 * (7 + dataBits + parityEn + twoStop);
    if (!rstN) begin
      mTimer <= 0; mPend <= 0; mReady <= 0;
    end else begin
      if (charIn) mReady <= 1;
      else if (fifoCount == 0) mReady <= 0;
      if (!fifoEn || fifoCount == 0) begin
        mTimer <= 0; mPend <= 0;
      end else if (mPend) begin
        if (hostRead) begin mPend <= 0; mTimer <= 0; end
      end else if (charIn || hostRead) begin
        mTimer <= 0;
      end else if (mTimer >= thr) begin
        mPend <= 1;
      end else if (baudTick) begin
        mTimer <= mTimer + 1;
      end
    end
  end

  function automatic bit actNow();
    return fifoEn && rxDataIe && rxLineIe;
  endfunction

  function automatic logic [3:0] expId();
    if (!actNow()) return 4'h1;
    if (lineErr) return 4'h6;
    if (fifoCount >= trigLevel) return 4'h4;
    if (mPend) return 4'hC;
    return 4'h1;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      chk(dataAvailIrq == (actNow() && fifoCount >= trigLevel), "R2 dataAvailIrq",
          dataAvailIrq, actNow() && fifoCount >= trigLevel);
      chk(timeoutIrq == (actNow() && mPend), "R5 timeoutIrq", timeoutIrq, actNow() && mPend);
      chk(dataReady == mReady, "R4 dataReady", dataReady, mReady);
      chk(irqId == expId(), "R3 irqId", irqId, expId());
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic probe();
    @(negedge clk);
  endtask

  task automatic addChar();
    charIn = 1; fifoCount = fifoCount + 1'b1;
    step(1);
    charIn = 0;
  endtask

  task automatic readChar();
    hostRead = 1; fifoCount = fifoCount - 1'b1;
    step(1);
    hostRead = 0;
  endtask

  task automatic finishRun();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    step(3);
    probe();
    chk(irqId == 4'h1 && !dataAvailIrq && !timeoutIrq && !dataReady, "R1 reset state",
        {dataReady, timeoutIrq, dataAvailIrq, irqId}, 1);
    rstN = 1;
    step(1);

    // R4: ready while interrupts are disabled
    addChar();
    probe();
    chk(dataReady == 1, "R4 ready with enables off", dataReady, 1);
    chk(dataAvailIrq == 0 && irqId == 4'h1, "R1 disabled", irqId, 1);

    fifoEn = 1; rxDataIe = 1; rxLineIe = 1; baudTick = 1; trigLevel = 5'd4;
    step(1);
    addChar(); addChar();
    probe();
    chk(dataAvailIrq == 0, "R2 below trigger", dataAvailIrq, 0);
    addChar();
    probe();
    chk(dataAvailIrq == 1 && irqId == 4'h4, "R2 at trigger", irqId, 4);
    lineErr = 1;
    probe();
    chk(irqId == 4'h6, "R3 line status first", irqId, 6);
    lineErr = 0;
    readChar();
    probe();
    chk(dataAvailIrq == 0 && irqId == 4'h1, "R2 dropped below", irqId, 1);

    // R1: one enable low masks everything
    rxLineIe = 0; addChar();
    probe();
    chk(dataAvailIrq == 0 && irqId == 4'h1, "R1 line enable low", irqId, 1);
    rxLineIe = 1;

    // R5: shortest frame, 448 ticks
    fifoCount = 5'd2;
    readChar();
    step(448);
    probe();
    chk(timeoutIrq == 0, "R5 not yet at limit", timeoutIrq, 0);
    step(1);
    probe();
    chk(timeoutIrq == 1 && irqId == 4'hC, "R5 time-out raised", irqId, 12);

    // R7: character while pending keeps it
    addChar();
    probe();
    chk(timeoutIrq == 1, "R7 char keeps pending", timeoutIrq, 1);
    // R9: mask and unmask
    rxDataIe = 0;
    probe();
    chk(timeoutIrq == 0, "R9 masked", timeoutIrq, 0);
    step(5);
    rxDataIe = 1;
    probe();
    chk(timeoutIrq == 1, "R9 still pending", timeoutIrq, 1);
    readChar();
    probe();
    chk(timeoutIrq == 0, "R7 read clears", timeoutIrq, 0);

    // R6: longest frame 768 ticks, a character restarts the timer
    dataBits = 2'd3; parityEn = 1; twoStop = 1;
    step(300);
    addChar();
    step(767);
    probe();
    chk(timeoutIrq == 0, "R6 restarted by char", timeoutIrq, 0);
    step(2);
    probe();
    chk(timeoutIrq == 1, "R5 long frame time-out", timeoutIrq, 1);

    // R8: emptying the FIFO drops the time-out
    fifoCount = 5'd1;
    readChar();
    step(1);
    probe();
    chk(timeoutIrq == 0 && dataReady == 0, "R8 empty drops", {timeoutIrq, dataReady}, 0);

    // R5: no baud ticks, no time-out
    baudTick = 0; addChar();
    step(2000);
    probe();
    chk(timeoutIrq == 0, "R5 ticks gate timer", timeoutIrq, 0);
    baudTick = 1;
    step(800);
    probe();
    chk(timeoutIrq == 1, "R5 resumes with ticks", timeoutIrq, 1);

    // R8: FIFO mode off drops the pending time-out, and R6 holds the timer
    fifoEn = 0;
    step(1);
    fifoEn = 1;
    probe();
    chk(timeoutIrq == 0, "R8 fifo off drops", timeoutIrq, 0);
    step(20);
    finishRun();
  end
endmodule